// File: doc/BRIEF.md
# Pixel Vector Multiply-Accumulate Unit

This block is a pixel arithmetic engine made of three dot-product lanes that run side by side. Each lane multiplies three unsigned 8-bit pixel operands by three signed coefficients and adds up the products. It then either adds a signed offset of its own or adds the sum into a private running accumulator. A shared output stage rounds, shifts and clamps each result back to an 8-bit pixel.

In colour-conversion mode all three lanes see the same three input components. Each lane produces one output channel, so one pixel is converted per cycle. In filter mode, component 0 of each accepted beat is a new sample. Together with the eight samples before it, it feeds a nine-tap window split across the lanes, three taps per lane. The three lane results are added into one filtered sample on channel 0, at one sample per cycle. Taps beyond nine are handled by running several passes with lane accumulation switched on.

Pixels enter and leave through valid/ready streams. Coefficients, offsets and the control word arrive through a simple write port. New settings are held in a staging copy and move into the working copy only while the pipeline is empty. A beat is accepted when `in_valid` and `in_ready` are both high. A result is taken when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, every pipeline stage holds, `in_ready` is low and `out_pix` does not change.

Top module: `pvm_top`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, `out_pix` is 0, and every staged and working coefficient, offset and control field is 0.
- R2: In colour mode (control bit 0 = 0), output channel u (bits 8u+7..8u) equals sat(scale(sum over t of pix[t]*coef[3u+t] + off[u])) for a lane u in offset mode, where pix[t] is `in_pix` bits 8t+7..8t.
- R3: Scaling adds 2^(s-1) when s>0 and then shifts arithmetically right by s, where s is control bits 7:4 (0 to 15).
- R4: Saturation maps scaled values below 0 to 0 and values above 255 to 255.
- R5: A lane whose accumulate bit is set (control bit 1+u for lane u) adds its dot product to its accumulator and outputs the new accumulator value; its offset has no effect.
- R6: A one-cycle pulse on `acc_clr` sets all three accumulators to zero.
- R7: In filter mode (control bit 0 = 1), each accepted beat shifts `in_pix` bits 7..0 into a nine-sample window x[0..8], with x[0] the newest. Lane u works on x[3u..3u+2] with coef[3u..3u+2]. Channel 0 is sat(scale(sum of the three lane results)), channels 1 and 2 are 0, and one beat is accepted per cycle.
- R8: A beat accepted in cycle c appears on `out_valid` in cycle c+3 when `out_ready` stays high.
- R9: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0, and `out_valid` and `out_pix` stay unchanged in the next cycle.
- R10: Register map for `cfg_addr`: 0..8 = coef[k] (data bits 11:0, signed), 9..11 = off[addr-9] (data bits 15:0, signed), 12 = control word. A write updates the staged copy. The working copy takes all staged values only on a clock edge where no beat is in the pipeline and `in_valid` is 0.
- R11: Writes to addresses 13 to 31 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| acc_clr | input | 1 | Zeroes all lane accumulators |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be accepted |
| in_pix | input | 24 | Three 8-bit input components, component t at bits 8t+7..8t |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes output beat |
| out_pix | output | 24 | Three 8-bit output channels, channel u at bits 8u+7..8u |

## Verification
The hardest case to reach is a configuration write that lands while beats are still in flight. If the working copy changed at the wrong moment, the outputs would mix old and new coefficients. The stimulus keeps `in_valid` high with `out_ready` tied high, issues a coefficient write partway through the burst, and checks that every beat still in that burst uses the old value. It then drains the pipeline and checks that the next burst uses the new one. A second hard case is back-pressure that arrives during a long filter burst, checked against a behavioural window and accumulator model with random `out_ready` stalls.

// File: rtl/pvm_pkg.sv
package pvm_pkg;
  localparam int N_UNIT  = 3;
  localparam int N_TERM  = 3;
  localparam int N_TAP   = N_UNIT * N_TERM;
  localparam int SHIFT_W = 4;
  localparam int ADDR_W  = 5;
  localparam int ADDR_OFF  = N_TAP;
  localparam int ADDR_CTRL = N_TAP + N_UNIT;

  typedef struct packed {
    logic [SHIFT_W-1:0] shift;
    logic [N_UNIT-1:0]  acc_en;
    logic               filt;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pvm_cfg_regs.sv
module pvm_cfg_regs
  import pvm_pkg::*;
#(
  parameter int COEF_W = 12,
  parameter int OFF_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic                     idle_i,
  output logic signed [COEF_W-1:0] coef_o [N_TAP],
  output logic signed [OFF_W-1:0]  off_o  [N_UNIT],
  output ctrl_t                    ctrl_o
);
  logic signed [COEF_W-1:0] coef_stg [N_TAP];
  logic signed [OFF_W-1:0]  off_stg  [N_UNIT];
  ctrl_t                    ctrl_stg;
  ctrl_t                    ctrl_act;

  for (genvar k = 0; k < N_TAP; k++) begin : g_coef
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        coef_stg[k] <= '0;
        coef_o[k]   <= '0;
      end else begin
        if (idle_i)
          coef_o[k] <= coef_stg[k];
        if (we_i && addr_i == ADDR_W'(k))
          coef_stg[k] <= wdata_i[COEF_W-1:0];
      end
    end
  end

  for (genvar u = 0; u < N_UNIT; u++) begin : g_off
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        off_stg[u] <= '0;
        off_o[u]   <= '0;
      end else begin
        if (idle_i)
          off_o[u] <= off_stg[u];
        if (we_i && addr_i == ADDR_W'(ADDR_OFF + u))
          off_stg[u] <= wdata_i[OFF_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_stg <= '0;
      ctrl_act <= '0;
    end else begin
      if (idle_i)
        ctrl_act <= ctrl_stg;
      if (we_i && addr_i == ADDR_W'(ADDR_CTRL))
        ctrl_stg <= ctrl_t'(wdata_i[CTRL_W-1:0]);
    end
  end

  assign ctrl_o = ctrl_act;

  // R10
  cfg_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_i |=> $stable(ctrl_act) && $stable(coef_o[0]) &&
                $stable(coef_o[N_TAP-1]) && $stable(off_o[0]));
endmodule

// File: rtl/pvm_dot_unit.sv
module pvm_dot_unit
  import pvm_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 12,
  parameter int OFF_W  = 16,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv_i,
  input  logic                     vld1_i,
  input  logic                     clr_i,
  input  logic                     acc_en_i,
  input  logic [PIX_W-1:0]         pix_i  [N_TERM],
  input  logic signed [COEF_W-1:0] coef_i [N_TERM],
  input  logic signed [OFF_W-1:0]  off_i,
  output logic signed [ACC_W-1:0]  res_o
);
  localparam int PROD_W = PIX_W + 1 + COEF_W;

  logic signed [PROD_W-1:0] prod_q [N_TERM];
  logic signed [ACC_W-1:0]  dot_w;
  logic signed [ACC_W-1:0]  acc_q;

  for (genvar t = 0; t < N_TERM; t++) begin : g_mul
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        prod_q[t] <= '0;
      else if (adv_i)
        prod_q[t] <= $signed({1'b0, pix_i[t]}) * coef_i[t];
    end
  end

  always_comb begin
    dot_w = '0;
    for (int t = 0; t < N_TERM; t++)
      dot_w = dot_w + ACC_W'(prod_q[t]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      res_o <= '0;
    else if (adv_i)
      res_o <= acc_en_i ? (acc_q + dot_w) : (dot_w + ACC_W'(off_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc_q <= '0;
    else if (clr_i)
      acc_q <= '0;
    else if (adv_i && vld1_i && acc_en_i)
      acc_q <= acc_q + dot_w;
  end

  // R6
  acc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> acc_q == '0);

  // R5
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en_i && !clr_i |=> $stable(acc_q));
endmodule

// File: rtl/pvm_scale_sat.sv
module pvm_scale_sat #(
  parameter int IN_W    = 34,
  parameter int SHIFT_W = 4,
  parameter int OUT_W   = 8
) (
  input  logic signed [IN_W-1:0] val_i,
  input  logic [SHIFT_W-1:0]     shift_i,
  output logic [OUT_W-1:0]       pix_o
);
  localparam logic signed [IN_W:0] MAXV = (IN_W+1)'((1 << OUT_W) - 1);

  logic signed [IN_W:0] rnd_w;
  logic signed [IN_W:0] sum_w;
  logic signed [IN_W:0] shr_w;

  always_comb begin
    rnd_w = $signed(((IN_W+1)'(1) << shift_i) >> 1);
    sum_w = $signed({val_i[IN_W-1], val_i}) + rnd_w;
    shr_w = sum_w >>> shift_i;
    if (shr_w < 0)
      pix_o = '0;
    else if (shr_w > MAXV)
      pix_o = '1;
    else
      pix_o = shr_w[OUT_W-1:0];
  end
endmodule

// File: rtl/pvm_top.sv
module pvm_top
  import pvm_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 12,
  parameter int OFF_W  = 16,
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [ADDR_W-1:0]         cfg_addr,
  input  logic [DATA_W-1:0]         cfg_wdata,
  input  logic                      acc_clr,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [N_TERM*PIX_W-1:0]   in_pix,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [N_UNIT*PIX_W-1:0]   out_pix
);
  localparam int SUM_W = ACC_W + 2;

  logic adv, accept, idle;
  logic s1_v, s2_v, s3_v;

  logic signed [COEF_W-1:0] coef_a [N_TAP];
  logic signed [OFF_W-1:0]  off_a  [N_UNIT];
  ctrl_t                    ctrl_a;

  logic [PIX_W-1:0]         pix_w  [N_TERM];
  logic [PIX_W-1:0]         tap_w  [N_TAP];
  logic [PIX_W-1:0]         hist_q [N_TAP];
  logic signed [ACC_W-1:0]  res_w  [N_UNIT];
  logic signed [SUM_W-1:0]  fsum_w;
  logic signed [SUM_W-1:0]  ch_in_w [N_UNIT];
  logic [PIX_W-1:0]         ch_out_w [N_UNIT];
  logic [PIX_W-1:0]         out_q   [N_UNIT];

  assign adv      = !(s3_v && !out_ready);
  assign in_ready = adv;
  assign accept   = in_valid && adv;
  assign idle     = !s1_v && !s2_v && !s3_v && !in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      s3_v <= 1'b0;
    end else if (adv) begin
      s1_v <= accept;
      s2_v <= s1_v;
      s3_v <= s2_v;
    end
  end

  pvm_cfg_regs #(
    .COEF_W(COEF_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .addr_i(cfg_addr),
    .wdata_i(cfg_wdata), .idle_i(idle),
    .coef_o(coef_a), .off_o(off_a), .ctrl_o(ctrl_a)
  );

  for (genvar t = 0; t < N_TERM; t++) begin : g_unpack
    assign pix_w[t] = in_pix[t*PIX_W +: PIX_W];
  end

  // sample window: tap 0 is the live sample, taps 1.. are history
  assign tap_w[0]  = pix_w[0];
  assign hist_q[0] = '0;
  for (genvar k = 1; k < N_TAP; k++) begin : g_hist
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        hist_q[k] <= '0;
      else if (accept && ctrl_a.filt)
        hist_q[k] <= (k == 1) ? pix_w[0] : hist_q[k-1];
    end
    assign tap_w[k] = hist_q[k];
  end

  for (genvar u = 0; u < N_UNIT; u++) begin : g_unit
    logic [PIX_W-1:0]         op_w [N_TERM];
    logic signed [COEF_W-1:0] cf_w [N_TERM];
    for (genvar t = 0; t < N_TERM; t++) begin : g_op
      assign op_w[t] = ctrl_a.filt ? tap_w[u*N_TERM + t] : pix_w[t];
      assign cf_w[t] = coef_a[u*N_TERM + t];
    end
    pvm_dot_unit #(
      .PIX_W(PIX_W), .COEF_W(COEF_W), .OFF_W(OFF_W), .ACC_W(ACC_W)
    ) u_dot (
      .clk(clk), .rst_n(rst_n), .adv_i(adv), .vld1_i(s1_v),
      .clr_i(acc_clr), .acc_en_i(ctrl_a.acc_en[u]),
      .pix_i(op_w), .coef_i(cf_w), .off_i(off_a[u]), .res_o(res_w[u])
    );
  end

  always_comb begin
    fsum_w = '0;
    for (int u = 0; u < N_UNIT; u++)
      fsum_w = fsum_w + SUM_W'(res_w[u]);
  end

  for (genvar c = 0; c < N_UNIT; c++) begin : g_out
    if (c == 0) begin : g_first
      assign ch_in_w[c] = ctrl_a.filt ? fsum_w : SUM_W'(res_w[c]);
    end else begin : g_other
      assign ch_in_w[c] = ctrl_a.filt ? '0 : SUM_W'(res_w[c]);
    end

    pvm_scale_sat #(
      .IN_W(SUM_W), .SHIFT_W(SHIFT_W), .OUT_W(PIX_W)
    ) u_sat (
      .val_i(ch_in_w[c]), .shift_i(ctrl_a.shift), .pix_o(ch_out_w[c])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        out_q[c] <= '0;
      else if (adv)
        out_q[c] <= ch_out_w[c];
    end
    assign out_pix[c*PIX_W +: PIX_W] = out_q[c];
  end

  assign out_valid = s3_v;

  // R8
  lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_ready) ##1 out_ready ##1 out_ready |=> out_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix));

  // R4
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s2_v && adv && !ctrl_a.filt && (res_w[0] < 0) |=> out_pix[PIX_W-1:0] == '0);
endmodule

// File: tb/tb_pvm_top.sv
module tb_pvm_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        acc_clr = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_pix = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_pix;

  pvm_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .acc_clr(acc_clr), .in_valid(in_valid),
    .in_ready(in_ready), .in_pix(in_pix), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(out_pix)
  );

  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int stall_pct = 0;
  string cur_req = "R2";

  // behavioural reference state
  int     coef_s[9], coef_a[9], off_s[3], off_a[3];
  int     ctl_s, ctl_a;
  longint acc[3];
  int     hist[8];
  int     eq0[$], eq1[$], eq2[$];
  bit     mv0, mv1, mv2, last_acc;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sat8(longint v, int s);
    longint r, y;
    r = (s == 0) ? 0 : (longint'(1) << (s - 1));
    y = (v + r) >>> s;
    if (y < 0) return 0;
    if (y > 255) return 255;
    return int'(y);
  endfunction

  task automatic model_accept(int p0, int p1, int p2);
    longint lr[3];
    int     op[3];
    int     tp[9];
    int     sh;
    bit     filt;
    longint fs;
    filt = ctl_a[0];
    sh   = (ctl_a >> 4) & 15;
    tp[0] = p0;
    for (int k = 1; k < 9; k++) tp[k] = hist[k-1];
    for (int u = 0; u < 3; u++) begin
      longint d;
      if (filt) begin
        op[0] = tp[3*u]; op[1] = tp[3*u+1]; op[2] = tp[3*u+2];
      end else begin
        op[0] = p0; op[1] = p1; op[2] = p2;
      end
      d = 0;
      for (int t = 0; t < 3; t++) d += longint'(op[t]) * coef_a[3*u+t];
      if (ctl_a[1+u]) begin
        acc[u] += d;
        lr[u] = acc[u];
      end else begin
        lr[u] = d + off_a[u];
      end
    end
    if (filt) begin
      fs = lr[0] + lr[1] + lr[2];
      eq0.push_back(sat8(fs, sh)); eq1.push_back(0); eq2.push_back(0);
      for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = p0;
    end else begin
      eq0.push_back(sat8(lr[0], sh));
      eq1.push_back(sat8(lr[1], sh));
      eq2.push_back(sat8(lr[2], sh));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      foreach (coef_s[k]) begin coef_s[k] = 0; coef_a[k] = 0; end
      foreach (off_s[u]) begin off_s[u] = 0; off_a[u] = 0; acc[u] = 0; end
      foreach (hist[k]) hist[k] = 0;
      ctl_s = 0; ctl_a = 0;
      mv0 = 0; mv1 = 0; mv2 = 0; last_acc = 0;
      eq0.delete(); eq1.delete(); eq2.delete();
    end else begin
      bit rdy, acc_now, idle;
      rdy = !(mv2 && !out_ready);
      acc_now = in_valid && rdy;
      idle = !mv0 && !mv1 && !mv2 && !in_valid;
      if (mv2 && out_ready && eq0.size() > 0) begin
        void'(eq0.pop_front()); void'(eq1.pop_front()); void'(eq2.pop_front());
      end
      if (acc_now) model_accept(in_pix[7:0], in_pix[15:8], in_pix[23:16]);
      if (rdy) begin mv2 = mv1; mv1 = mv0; mv0 = acc_now; end
      if (acc_clr) foreach (acc[u]) acc[u] = 0;
      if (idle) begin
        coef_a = coef_s; off_a = off_s; ctl_a = ctl_s;
      end
      if (cfg_we) begin
        if (cfg_addr < 9) coef_s[cfg_addr] = int'($signed(cfg_wdata[11:0]));
        else if (cfg_addr < 12) off_s[cfg_addr-9] = int'($signed(cfg_wdata));
        else if (cfg_addr == 12) ctl_s = cfg_wdata[7:0];
      end
      last_acc = acc_now;
    end
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL R8 watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      chk(out_valid == mv2, "R8", "out_valid", out_valid, mv2);
      chk(in_ready == !(mv2 && !out_ready), "R9", "in_ready", in_ready, !(mv2 && !out_ready));
      if (mv2 && out_valid && eq0.size() > 0) begin
        chk(out_pix[7:0]   == eq0[0], cur_req, "ch0", out_pix[7:0],   eq0[0]);
        chk(out_pix[15:8]  == eq1[0], cur_req, "ch1", out_pix[15:8],  eq1[0]);
        chk(out_pix[23:16] == eq2[0], cur_req, "ch2", out_pix[23:16], eq2[0]);
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = ($urandom_range(0, 99) >= stall_pct);
    end
  end

  task automatic cfg_wr(int a, int d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 16'(d);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic ctrl_wr(bit filt, int accen, int sh);
    cfg_wr(12, (sh << 4) | (accen << 1) | int'(filt));
  endtask

  task automatic send(int p0, int p1, int p2);
    in_valid = 1'b1;
    in_pix = {8'(p2), 8'(p1), 8'(p0)};
    do begin
      @(posedge clk); #1;
    end while (!last_acc);
  endtask

  task automatic drain();
    in_valid = 1'b0;
    do begin
      @(posedge clk); #1;
    end while (mv0 || mv1 || mv2);
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic clear_acc();
    @(posedge clk); #1;
    acc_clr = 1'b1;
    @(posedge clk); #1;
    acc_clr = 1'b0;
  endtask

  task automatic burst(int n);
    for (int i = 0; i < n; i++)
      send($urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255));
    drain();
  endtask

  initial begin
    int lat;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
    chk(out_pix == 24'd0, "R1", "out_pix", out_pix, 0);
    send(200, 100, 50);
    drain();

    // R2 colour conversion, shift 8
    cur_req = "R2";
    cfg_wr(0, 77);  cfg_wr(1, 150); cfg_wr(2, 29);
    cfg_wr(3, -43 & 16'hfff); cfg_wr(4, -85 & 16'hfff); cfg_wr(5, 128);
    cfg_wr(6, 128); cfg_wr(7, -107 & 16'hfff); cfg_wr(8, -21 & 16'hfff);
    cfg_wr(9, 0); cfg_wr(10, 32767); cfg_wr(11, 32767);
    ctrl_wr(0, 0, 8);
    drain();
    stall_pct = 0;
    burst(24);

    // R9 heavy back-pressure
    cur_req = "R9";
    stall_pct = 60;
    burst(30);
    stall_pct = 20;

    // R4 saturation both ways, shift 0
    cur_req = "R4";
    cfg_wr(0, 2047); cfg_wr(1, 2047); cfg_wr(2, 2047);
    cfg_wr(3, 16'hf800); cfg_wr(4, 16'hf800); cfg_wr(5, 16'hf800);
    cfg_wr(6, 1); cfg_wr(7, 0); cfg_wr(8, 0);
    cfg_wr(9, 0); cfg_wr(10, 0); cfg_wr(11, 16'hff00);
    ctrl_wr(0, 0, 0);
    drain();
    send(255, 255, 255); send(0, 0, 0); send(1, 2, 3); send(255, 0, 0);
    burst(8);

    // R3 rounding at half steps, shift 1 and 3
    cur_req = "R3";
    cfg_wr(0, 1); cfg_wr(1, 0); cfg_wr(2, 0);
    cfg_wr(3, 16'hfff); cfg_wr(4, 0); cfg_wr(5, 0);
    cfg_wr(6, 3); cfg_wr(7, 0); cfg_wr(8, 0);
    cfg_wr(11, 16'h0100);
    ctrl_wr(0, 0, 1);
    drain();
    send(1, 0, 0); send(3, 0, 0); send(4, 0, 0);
    burst(10);
    ctrl_wr(0, 0, 3);
    drain();
    send(4, 0, 0); send(12, 0, 0); send(11, 0, 0);
    burst(10);
    ctrl_wr(0, 0, 15);
    drain();
    burst(6);

    // R5 accumulation on lanes 0 and 1, lane 2 offset; R6 clear
    cur_req = "R5";
    cfg_wr(0, 1); cfg_wr(1, 1); cfg_wr(2, 1);
    cfg_wr(3, 2); cfg_wr(4, 0); cfg_wr(5, 16'hfff);
    cfg_wr(6, 1); cfg_wr(7, 1); cfg_wr(8, 1);
    cfg_wr(9, 1000); cfg_wr(10, 1000); cfg_wr(11, 40);
    ctrl_wr(0, 3, 4);
    drain();
    clear_acc();
    burst(4);
    cur_req = "R6";
    clear_acc();
    send(10, 20, 30);
    burst(3);
    clear_acc();
    stall_pct = 40;
    burst(6);
    stall_pct = 20;

    // R7 nine-tap filter
    cur_req = "R7";
    cfg_wr(0, 64); cfg_wr(1, 32); cfg_wr(2, 16);
    cfg_wr(3, 8);  cfg_wr(4, 16'hff0); cfg_wr(5, 4);
    cfg_wr(6, 2);  cfg_wr(7, 1); cfg_wr(8, 16'hfff);
    cfg_wr(9, 0); cfg_wr(10, 0); cfg_wr(11, 0);
    ctrl_wr(1, 0, 6);
    drain();
    stall_pct = 25;
    burst(40);
    // longer filter: lane 2 accumulates across passes
    ctrl_wr(1, 4, 7);
    drain();
    clear_acc();
    burst(12);
    stall_pct = 0;
    burst(9);

    // R10 write during a busy burst must wait for idle
    cur_req = "R10";
    cfg_wr(0, 100); cfg_wr(1, 0); cfg_wr(2, 0);
    cfg_wr(3, 0); cfg_wr(4, 100); cfg_wr(5, 0);
    cfg_wr(6, 0); cfg_wr(7, 0); cfg_wr(8, 100);
    ctrl_wr(0, 0, 7);
    drain();
    for (int i = 0; i < 12; i++) begin
      send(i * 20, 255 - i * 20, 128);
      if (i == 4) begin
        cfg_we = 1'b1; cfg_addr = 5'd0; cfg_wdata = 16'd300;
      end
      if (i == 5) cfg_we = 1'b0;
    end
    drain();
    burst(6);

    // R11 writes outside the map
    cur_req = "R11";
    cfg_wr(13, 16'hffff); cfg_wr(20, 16'h1234); cfg_wr(31, 16'h00ff);
    drain();
    burst(6);

    // R8 latency with no stall
    stall_pct = 0;
    drain();
    send(50, 60, 70);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 10) begin
      @(posedge clk); #1;
      lat++;
    end
    chk(lat == 3, "R8", "latency cycles", lat, 3);
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule